// File: doc/BRIEF.md
# Frame Buffer Operand and Result Bus Steering

This block sits between a double-buffered frame buffer and one column of an eight-cell compute array. The frame buffer holds two sets. Each set has two banks, A and B, and each bank holds 64 rows of eight bytes. The array works on one set, chosen by `array_set`. At the same time, a transfer port fills or updates the other set, so loading overlaps with compute.

**Read side.** Each read takes one row from bank A and one row from bank B of the array's set. It packs the two rows onto a 128-bit operand bus made of eight 16-bit segments, one segment per array row. Two packing orders are available:
- Interleaved order gives every cell one byte from each bank.
- Contiguous order gives every cell two adjacent bytes from a single bank.

**Write side.** The result bus carries eight 16-bit cell results. It is gathered into bank rows in one of two modes:
- 8-bit mode takes the low byte of each cell and writes one 64-bit row into a chosen bank.
- 16-bit mode splits the column: the upper half of the array goes to bank B, the lower half to bank A.

**Transfer port.** This port is valid/ready. The sender raises `xfer_valid` and holds set, bank, row and data stable until a cycle in which `xfer_ready` is high; the word is written at that edge. `xfer_ready` depends only on whether the target set is the one the array is using. A transfer aimed at the array's set waits, with `xfer_busy` raised, until `array_set` changes. The read side and the result side are plain strobes with no back-pressure.

Top module: `fbuf_steer`

## Requirements
- R1: While reset is held, and after its release until the first read, `opnd_vld` is 0 and `opnd_bus` is all zero.
- R2: A read presented with `rd_en` high at clock edge n appears at edge n+1, and `opnd_vld` is high for exactly that cycle. The read takes row `rd_row_a` of bank A and row `rd_row_b` of bank B in set `array_set`. It returns the contents as they were before any write at that same edge.
- R3: With `opnd_mode`=0 (interleaved), bus byte 2i (bits 16i+7:16i) is byte i of the bank A row, and bus byte 2i+1 is byte i of the bank B row. Byte j of a row is bits 8j+7:8j.
- R4: With `opnd_mode`=1 (contiguous), bus bytes 0 to 7 are bytes 0 to 7 of the bank A row, and bus bytes 8 to 15 are bytes 0 to 7 of the bank B row.
- R5: `res_valid` with `res_mode`=0 (8-bit) writes row `res_row` of the array's set. Byte k of that row takes bits 7:0 of result segment k (bits 16k+15:16k). The bank is chosen by `res_bank` (0 = A, 1 = B), and the other bank is left unchanged.
- R6: `res_valid` with `res_mode`=1 (16-bit) writes segments 0 to 3 into row `res_row` of bank A, segment k in bytes 2k and 2k+1 with its low byte first. It writes segments 4 to 7 in the same way into the same row of bank B. `res_bank` has no effect in this mode.
- R7: `xfer_ready` is high exactly when `xfer_set` differs from `array_set`. A cycle with `xfer_valid` and `xfer_ready` both high writes `xfer_data` into row `xfer_row` of bank `xfer_bank` (0 = A, 1 = B) of set `xfer_set`.
- R8: While `xfer_valid` is high and `xfer_set` equals `array_set`, `xfer_busy` is high and nothing is written. Once `array_set` changes, the held transfer is accepted.
- R9: In a cycle after one with `rd_en` low, `opnd_vld` is 0 and `opnd_bus` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| array_set | input | 1 | Set currently owned by the array |
| rd_en | input | 1 | Operand read strobe |
| rd_row_a | input | 6 | Bank A row for the operand read |
| rd_row_b | input | 6 | Bank B row for the operand read |
| opnd_mode | input | 1 | 0 interleaved, 1 contiguous |
| opnd_vld | output | 1 | Operand bus carries read data |
| opnd_bus | output | 128 | Eight 16-bit operand segments |
| res_valid | input | 1 | Result write strobe |
| res_mode | input | 1 | 0 8-bit, 1 16-bit |
| res_bank | input | 1 | Target bank in 8-bit mode |
| res_row | input | 6 | Row written by the result |
| res_bus | input | 128 | Eight 16-bit cell results |
| xfer_valid | input | 1 | Transfer write offered |
| xfer_ready | output | 1 | Transfer write can be taken |
| xfer_set | input | 1 | Transfer target set |
| xfer_bank | input | 1 | Transfer target bank |
| xfer_row | input | 6 | Transfer target row |
| xfer_data | input | 64 | Transfer row data |
| xfer_busy | output | 1 | Transfer waiting on the array's set |

## Verification
The bench targets the corner cases below, and each has a visible symptom if the design gets it wrong:
- **Byte order of both packings.** A swapped byte order in either packing shows up as misplaced bytes on specific segments.
- **Result write into a row read at the same edge.** A write-first memory would return the new row at the same edge, where the old row is expected.
- **8-bit result mode.** Writing both banks in this mode would corrupt the other bank's row, which the following contiguous read exposes.
- **16-bit result mode.** Honouring `res_bank` here would drop one half of the column.
- **Transfer held against the array's set.** A design that lets it through would show the new data on a read taken during the wait. A design that drops the transfer would show old data after the set swap.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  typedef enum logic {
    PACK_ILV    = 1'b0,
    PACK_CONTIG = 1'b1
  } pack_mode_e;

  typedef enum logic {
    RES_BYTE = 1'b0,
    RES_HALF = 1'b1
  } res_mode_e;

  localparam int NUM_SETS  = 2;
  localparam int NUM_BANKS = 2;
  localparam int BANK_A    = 0;
  localparam int BANK_B    = 1;
endpackage

// File: rtl/fb_bank.sv
module fb_bank #(
  parameter  int DEPTH = 64,
  parameter  int WIDTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_we,
  input  logic [AW-1:0]    res_addr,
  input  logic [WIDTH-1:0] res_data,
  input  logic             xf_we,
  input  logic [AW-1:0]    xf_addr,
  input  logic [WIDTH-1:0] xf_data,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic             we;
  logic [AW-1:0]    waddr;
  logic [WIDTH-1:0] wdata;

  always_comb begin
    we    = res_we | xf_we;
    waddr = res_we ? res_addr : xf_addr;
    wdata = res_we ? res_data : xf_data;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // old contents on a same-edge collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  // R7: array-side and transfer-side never target one bank together
  a_r7_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_we && xf_we));
endmodule

// File: rtl/fb_gather.sv
module fb_gather
  import fbuf_pkg::*;
#(
  parameter  int CELLS  = 8,
  parameter  int BYTE_W = 8,
  localparam int SEG_W  = 2 * BYTE_W,
  localparam int BUS_W  = CELLS * SEG_W,
  localparam int ROW_W  = CELLS * BYTE_W,
  localparam int HALF   = CELLS / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  res_mode_e        mode,
  input  logic             bank_sel,
  input  logic [BUS_W-1:0] res_bus,
  output logic [1:0]       bank_we,
  output logic [ROW_W-1:0] wdata_a,
  output logic [ROW_W-1:0] wdata_b
);
  logic [ROW_W-1:0] byte_row;
  logic [ROW_W-1:0] half_lo;
  logic [ROW_W-1:0] half_hi;

  for (genvar k = 0; k < CELLS; k++) begin : g_byte
    assign byte_row[k*BYTE_W +: BYTE_W] = res_bus[k*SEG_W +: BYTE_W];
  end

  for (genvar k = 0; k < HALF; k++) begin : g_half
    assign half_lo[k*SEG_W +: SEG_W] = res_bus[k*SEG_W +: SEG_W];
    assign half_hi[k*SEG_W +: SEG_W] = res_bus[(k+HALF)*SEG_W +: SEG_W];
  end

  always_comb begin
    bank_we = 2'b00;
    if (valid) begin
      if (mode == RES_HALF) bank_we = 2'b11;
      else                  bank_we = bank_sel ? 2'b10 : 2'b01;
    end
    wdata_a = (mode == RES_HALF) ? half_lo : byte_row;
    wdata_b = (mode == RES_HALF) ? half_hi : byte_row;
  end

  // R5: byte mode touches a single bank
  a_r5_byte_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode == RES_BYTE) |-> $countones(bank_we) == 1);
  // R6: half mode splits the column across both banks
  a_r6_half_both_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode == RES_HALF) |-> bank_we == 2'b11);
endmodule

// File: rtl/fb_pack.sv
module fb_pack
  import fbuf_pkg::*;
#(
  parameter  int CELLS  = 8,
  parameter  int BYTE_W = 8,
  localparam int SEG_W  = 2 * BYTE_W,
  localparam int BUS_W  = CELLS * SEG_W,
  localparam int ROW_W  = CELLS * BYTE_W
) (
  input  pack_mode_e       mode,
  input  logic [ROW_W-1:0] row_a,
  input  logic [ROW_W-1:0] row_b,
  output logic [BUS_W-1:0] bus
);
  logic [BUS_W-1:0] ilv;
  logic [BUS_W-1:0] contig;

  for (genvar i = 0; i < CELLS; i++) begin : g_ilv
    assign ilv[i*SEG_W +: BYTE_W]          = row_a[i*BYTE_W +: BYTE_W];
    assign ilv[i*SEG_W + BYTE_W +: BYTE_W] = row_b[i*BYTE_W +: BYTE_W];
  end

  assign contig = {row_b, row_a};

  always_comb bus = (mode == PACK_CONTIG) ? contig : ilv;
endmodule

// File: rtl/fbuf_steer.sv
module fbuf_steer
  import fbuf_pkg::*;
#(
  parameter  int CELLS  = 8,
  parameter  int BYTE_W = 8,
  parameter  int DEPTH  = 64,
  localparam int AW     = $clog2(DEPTH),
  localparam int SEG_W  = 2 * BYTE_W,
  localparam int BUS_W  = CELLS * SEG_W,
  localparam int ROW_W  = CELLS * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             array_set,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_row_a,
  input  logic [AW-1:0]    rd_row_b,
  input  logic             opnd_mode,
  output logic             opnd_vld,
  output logic [BUS_W-1:0] opnd_bus,
  input  logic             res_valid,
  input  logic             res_mode,
  input  logic             res_bank,
  input  logic [AW-1:0]    res_row,
  input  logic [BUS_W-1:0] res_bus,
  input  logic             xfer_valid,
  output logic             xfer_ready,
  input  logic             xfer_set,
  input  logic             xfer_bank,
  input  logic [AW-1:0]    xfer_row,
  input  logic [ROW_W-1:0] xfer_data,
  output logic             xfer_busy
);
  logic [1:0]       g_we;
  logic [ROW_W-1:0] g_wd_a, g_wd_b;
  logic [ROW_W-1:0] bank_q [NUM_SETS][NUM_BANKS];
  logic [NUM_SETS*NUM_BANKS-1:0] xf_we_vec;
  logic             rd_set_q;
  pack_mode_e       mode_q;

  assign xfer_ready = (xfer_set != array_set);
  assign xfer_busy  = xfer_valid & ~xfer_ready;

  fb_gather #(.CELLS(CELLS), .BYTE_W(BYTE_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .valid(res_valid),
    .mode(res_mode_e'(res_mode)), .bank_sel(res_bank), .res_bus(res_bus),
    .bank_we(g_we), .wdata_a(g_wd_a), .wdata_b(g_wd_b)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic own;
      assign own = (array_set == 1'(s));
      assign xf_we_vec[s*NUM_BANKS+b] = xfer_valid & xfer_ready &
                                        (xfer_set == 1'(s)) & (xfer_bank == 1'(b));
      fb_bank #(.DEPTH(DEPTH), .WIDTH(ROW_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .res_we(g_we[b] & own), .res_addr(res_row),
        .res_data((b == BANK_A) ? g_wd_a : g_wd_b),
        .xf_we(xf_we_vec[s*NUM_BANKS+b]), .xf_addr(xfer_row), .xf_data(xfer_data),
        .re(rd_en & own), .raddr((b == BANK_A) ? rd_row_a : rd_row_b),
        .rdata(bank_q[s][b])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_vld <= 1'b0;
      rd_set_q <= 1'b0;
      mode_q   <= PACK_ILV;
    end else begin
      opnd_vld <= rd_en;
      if (rd_en) begin
        rd_set_q <= array_set;
        mode_q   <= pack_mode_e'(opnd_mode);
      end
    end
  end

  fb_pack #(.CELLS(CELLS), .BYTE_W(BYTE_W)) u_pack (
    .mode(mode_q), .row_a(bank_q[rd_set_q][BANK_A]),
    .row_b(bank_q[rd_set_q][BANK_B]), .bus(opnd_bus)
  );

  // R8: a waiting transfer writes no bank
  a_r8_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> xf_we_vec == '0);
  // R2: valid data only follows a read request
  a_r2_vld_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_vld |-> $past(rd_en));
  // R9: no request, no change on the operand bus
  a_r9_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(opnd_bus));
endmodule

// File: tb/sim_fbuf_steer.sv
module sim_fbuf_steer;
  localparam int RW = 6;

  logic clk = 0, rst_n = 0;
  logic array_set = 0, rd_en = 0, opnd_mode = 0;
  logic [RW-1:0] rd_row_a = 0, rd_row_b = 0, res_row = 0, xfer_row = 0;
  logic opnd_vld, xfer_ready, xfer_busy;
  logic [127:0] opnd_bus, res_bus = 0;
  logic res_valid = 0, res_mode = 0, res_bank = 0;
  logic xfer_valid = 0, xfer_set = 0, xfer_bank = 0;
  logic [63:0] xfer_data = 0;

  int tests = 0, fails = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  fbuf_steer u0 (
    .clk(clk), .rst_n(rst_n), .array_set(array_set), .rd_en(rd_en),
    .rd_row_a(rd_row_a), .rd_row_b(rd_row_b), .opnd_mode(opnd_mode),
    .opnd_vld(opnd_vld), .opnd_bus(opnd_bus), .res_valid(res_valid),
    .res_mode(res_mode), .res_bank(res_bank), .res_row(res_row), .res_bus(res_bus),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_set(xfer_set),
    .xfer_bank(xfer_bank), .xfer_row(xfer_row), .xfer_data(xfer_data),
    .xfer_busy(xfer_busy)
  );

  // behavioural reference
  logic [63:0] m [2][2][64];
  logic        exp_vld = 0;
  logic [127:0] exp_bus = 0;
  logic        exp_mode = 0;

  initial begin
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < 64; r++) m[s][b][r] = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_vld = 0;
      exp_bus = '0;
    end else begin
      exp_vld = rd_en;
      if (rd_en) begin
        logic [63:0] ra, rb;
        ra = m[array_set][0][rd_row_a];
        rb = m[array_set][1][rd_row_b];
        exp_mode = opnd_mode;
        for (int j = 0; j < 16; j++) begin
          if (!opnd_mode) exp_bus[8*j +: 8] = (j % 2 == 0) ? ra[8*(j/2) +: 8] : rb[8*(j/2) +: 8];
          else            exp_bus[8*j +: 8] = (j < 8) ? ra[8*j +: 8] : rb[8*(j-8) +: 8];
        end
      end
      if (res_valid) begin
        if (!res_mode) begin
          for (int k = 0; k < 8; k++)
            m[array_set][res_bank][res_row][8*k +: 8] = res_bus[16*k +: 8];
        end else begin
          for (int k = 0; k < 4; k++) begin
            m[array_set][0][res_row][16*k +: 16] = res_bus[16*k +: 16];
            m[array_set][1][res_row][16*k +: 16] = res_bus[16*(k+4) +: 16];
          end
        end
      end
      if (xfer_valid && xfer_set != array_set)
        m[xfer_set][xfer_bank][xfer_row] = xfer_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (phase %s): actual %h expected %h at %0t", req, cur_req, act, exp, $time);
    end
  endtask

  // compared every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk(opnd_vld === exp_vld, exp_vld ? "R2" : "R9", 128'(opnd_vld), 128'(exp_vld));
      chk(opnd_bus === exp_bus, exp_mode ? "R4" : "R3", opnd_bus, exp_bus);
      chk(xfer_ready === (xfer_set != array_set), "R7", 128'(xfer_ready), 128'(xfer_set != array_set));
      chk(xfer_busy === (xfer_valid && xfer_set == array_set), "R8",
          128'(xfer_busy), 128'(xfer_valid && xfer_set == array_set));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [63:0] pat(int s, int b, int r);
    return 64'(64'h9E3779B97F4A7C15 * 64'(r*4 + s*2 + b + 1)) ^ 64'(r << 8);
  endfunction

  task automatic xfer(input logic s, input logic b, input int r, input logic [63:0] d);
    xfer_valid = 1; xfer_set = s; xfer_bank = b; xfer_row = RW'(r); xfer_data = d;
    tick();
    xfer_valid = 0;
  endtask

  task automatic rd(input int a, input int b, input logic md);
    rd_en = 1; rd_row_a = RW'(a); rd_row_b = RW'(b); opnd_mode = md;
    tick();
    rd_en = 0;
  endtask

  task automatic res(input logic md, input logic bk, input int r, input logic [127:0] d);
    res_valid = 1; res_mode = md; res_bank = bk; res_row = RW'(r); res_bus = d;
    tick();
    res_valid = 0;
  endtask

  initial begin
    #(8*200000);
    fails++;
    $display("FAIL watchdog R2: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(opnd_vld === 1'b0, "R1", 128'(opnd_vld), 128'(0));
    chk(opnd_bus === '0, "R1", opnd_bus, '0);
    #1 rst_n = 1;
    tick();
    @(negedge clk);
    chk(opnd_vld === 1'b0 && opnd_bus === '0, "R1", opnd_bus, '0);
    tick();

    cur_req = "R7";
    array_set = 0;
    for (int r = 0; r < 64; r++) for (int b = 0; b < 2; b++) xfer(1, b[0], r, pat(1, b, r));
    array_set = 1;
    tick();
    for (int r = 0; r < 64; r++) for (int b = 0; b < 2; b++) xfer(0, b[0], r, pat(0, b, r));

    cur_req = "R3";
    rd(3, 7, 0); rd(40, 63, 0);
    tick();
    cur_req = "R4";
    rd(10, 10, 1); rd(0, 1, 1); rd(62, 5, 0);
    cur_req = "R9";
    tick(); tick();

    cur_req = "R5";
    res(0, 0, 20, 128'h1111_22A2_3333_44B4_5555_66C6_7777_88D8);
    rd(20, 20, 1);
    res(0, 1, 21, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F);
    rd(21, 21, 1); rd(21, 21, 0);

    cur_req = "R6";
    res(1, 1, 22, 128'hCAFE_BABE_DEAD_BEEF_0123_4567_89AB_CDEF);
    rd(22, 22, 1); rd(22, 22, 0);

    cur_req = "R2";
    rd_en = 1; rd_row_a = 23; rd_row_b = 23; opnd_mode = 1;
    res_valid = 1; res_mode = 1; res_row = 23; res_bus = {8{16'h5AA5}};
    tick();
    rd_en = 0; res_valid = 0;
    rd(23, 23, 1);
    array_set = 0;
    rd(5, 9, 1);

    cur_req = "R8";
    xfer_valid = 1; xfer_set = 0; xfer_bank = 1; xfer_row = 5; xfer_data = 64'h0BAD_F00D_1234_5678;
    tick();
    @(negedge clk);
    chk(xfer_busy === 1'b1 && xfer_ready === 1'b0, "R8", 128'({xfer_busy, xfer_ready}), 128'(2'b10));
    rd(5, 5, 1);
    rd(5, 5, 0);
    array_set = 1;
    tick();
    xfer_valid = 0;
    array_set = 0;
    rd(5, 5, 1);
    tick();
    @(negedge clk);
    chk(opnd_bus[127:64] === 64'h0BAD_F00D_1234_5678, "R8", 128'(opnd_bus[127:64]), 128'(64'h0BAD_F00D_1234_5678));
    tick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule